// File: doc/BRIEF.md
# Masked Interrupt Controller with Exception Select

This block gathers up to 32 external interrupt lines for a small processor core and turns them into one hard interrupt request. A per-line pending bit follows the line's transitions. A rising line sets its pending bit and a falling line clears it. Software can also clear pending bits by writing ones. A mask register decides which pending lines may raise the request. Software can add bits to the mask but can never remove them; only reset clears it.

The block also takes a timer tick request and two enable bits from the core's status register. From these it chooses which exception the core should take: none, external interrupt, or tick. A tick beats an external interrupt. The request, valid flag and code are registered. All pins are plain control and status pins, and no stream flows through the block, so there is no valid/ready handshake and no back-pressure. A register write is a single-cycle strobe with a one-bit select.

Top module: `irq_ctrl_top`

## Requirements
- R1: After reset, and whenever reset is asserted again, the mask readout, the pending readout, `hard_req`, `exc_valid` and `exc_code` are all zero.
- R2: Pending bit i is set by a 0-to-1 change of `irq_lines[i]` and is cleared by a 1-to-0 change. It appears on `pend_rd` right after the clock edge that samples the change.
- R3: A write with `wr_sel`=0 ORs `wr_data` into the mask. No write ever clears a mask bit.
- R4: A write with `wr_sel`=1 clears every pending bit whose `wr_data` bit is 1. Other bits keep their value. A cleared bit stays clear while its line is held high.
- R5: When a line changes and a clearing write hits the same bit in the same cycle, the line change wins. A rising line leaves the bit set.
- R6: `hard_req` is 1 exactly when, at the previous clock edge, some bit was set in both pending and mask.
- R7: `exc_code` is 2'b01 (external) only when the previous edge saw a masked pending bit with `ie_bit`=1, and no tick was selected.
- R8: `exc_code` is 2'b10 (tick) whenever the previous edge saw `tick_req`=1 with `te_bit`=1, even if an external interrupt was also enabled. Otherwise the code is 2'b00 (none), or 2'b01 per R7.
- R9: `exc_valid` is 1 exactly when `exc_code` is not 2'b00.
- R10: `mask_rd` and `pend_rd` show the register contents directly, with no added delay, so software can poll them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | 32 | External interrupt lines |
| wr_en | input | 1 | Single-cycle register write strobe |
| wr_sel | input | 1 | Write target: 0 mask (OR-in), 1 pending (write-one-to-clear) |
| wr_data | input | 32 | Write value |
| tick_req | input | 1 | Timer tick request |
| ie_bit | input | 1 | Core status: external interrupt enable |
| te_bit | input | 1 | Core status: tick enable |
| mask_rd | output | 32 | Current mask |
| pend_rd | output | 32 | Current pending bits |
| hard_req | output | 1 | Hard interrupt request, registered |
| exc_valid | output | 1 | An exception is selected |
| exc_code | output | 2 | 00 none, 01 external, 10 tick |

## Verification
A wrong pending or mask bit shows on `pend_rd` or `mask_rd` right after the edge that set it. The same fault shows one edge later as a wrong `hard_req` or `exc_code`. Mask writes and clearing writes are applied both while a line is held and while it changes. This separates level following from edge following, and it exposes any mask write that clears bits. Tick and external enables are combined in every pairing, so a swapped priority shows up as a wrong code in the very next cycle.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  typedef enum logic [1:0] {
    EXC_NONE = 2'b00,
    EXC_EXT  = 2'b01,
    EXC_TICK = 2'b10
  } exc_code_e;

  localparam logic WSEL_MASK = 1'b0;
  localparam logic WSEL_PEND = 1'b1;
endpackage

// File: rtl/irq_pend_track.sv
module irq_pend_track #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lines,
  input  logic         clr_en,
  input  logic [N-1:0] clr_bits,
  output logic [N-1:0] pend
);
  logic [N-1:0] prev_q;
  logic [N-1:0] pend_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic rise, fall;
    assign rise = lines[i] & ~prev_q[i];
    assign fall = ~lines[i] & prev_q[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q[i] <= 1'b0;
        pend_q[i] <= 1'b0;
      end else begin
        prev_q[i] <= lines[i];
        if (rise)                       pend_q[i] <= 1'b1;
        else if (fall)                  pend_q[i] <= 1'b0;
        else if (clr_en && clr_bits[i]) pend_q[i] <= 1'b0;
      end
    end
  end

  assign pend = pend_q;
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_en,
  input  logic [N-1:0] set_bits,
  output logic [N-1:0] mask
);
  logic [N-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mask_q <= '0;
    else if (set_en) mask_q <= mask_q | set_bits;
  end

  assign mask = mask_q;
endmodule

// File: rtl/irq_exc_select.sv
module irq_exc_select
  import irq_ctrl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       any_pend,
  input  logic       tick_req,
  input  logic       ie_bit,
  input  logic       te_bit,
  output logic       hard_req,
  output logic       exc_valid,
  output logic [1:0] exc_code
);
  exc_code_e code_d, code_q;
  logic      req_q;

  always_comb begin
    code_d = EXC_NONE;
    if (any_pend && ie_bit)   code_d = EXC_EXT;
    if (tick_req && te_bit)   code_d = EXC_TICK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      code_q <= EXC_NONE;
    end else begin
      req_q  <= any_pend;
      code_q <= code_d;
    end
  end

  assign hard_req  = req_q;
  assign exc_code  = code_q;
  assign exc_valid = (code_q != EXC_NONE);
endmodule

// File: rtl/irq_ctrl_top.sv
module irq_ctrl_top
  import irq_ctrl_pkg::*;
#(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] irq_lines,
  input  logic         wr_en,
  input  logic         wr_sel,
  input  logic [N-1:0] wr_data,
  input  logic         tick_req,
  input  logic         ie_bit,
  input  logic         te_bit,
  output logic [N-1:0] mask_rd,
  output logic [N-1:0] pend_rd,
  output logic         hard_req,
  output logic         exc_valid,
  output logic [1:0]   exc_code
);
  logic         mask_wr, pend_wr;
  logic [N-1:0] mask_w, pend_w;
  logic         any_pend;

  assign mask_wr = wr_en && (wr_sel == WSEL_MASK);
  assign pend_wr = wr_en && (wr_sel == WSEL_PEND);

  irq_mask_reg #(.N(N)) mask_i (
    .clk(clk), .rst_n(rst_n), .set_en(mask_wr), .set_bits(wr_data), .mask(mask_w)
  );

  irq_pend_track #(.N(N)) pend_i (
    .clk(clk), .rst_n(rst_n), .lines(irq_lines),
    .clr_en(pend_wr), .clr_bits(wr_data), .pend(pend_w)
  );

  assign any_pend = |(pend_w & mask_w);

  irq_exc_select sel_i (
    .clk(clk), .rst_n(rst_n), .any_pend(any_pend), .tick_req(tick_req),
    .ie_bit(ie_bit), .te_bit(te_bit),
    .hard_req(hard_req), .exc_valid(exc_valid), .exc_code(exc_code)
  );

  assign mask_rd = mask_w;
  assign pend_rd = pend_w;
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter int N = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick_req,
  input logic         ie_bit,
  input logic         te_bit,
  input logic [N-1:0] mask_rd,
  input logic [N-1:0] pend_rd,
  input logic         hard_req,
  input logic         exc_valid,
  input logic [1:0]   exc_code
);
  // R6
  req_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hard_req == $past(|(pend_rd & mask_rd)));

  // R9
  valid_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid == (exc_code != 2'b00));

  // R3
  mask_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_rd & $past(mask_rd)) == $past(mask_rd));

  // R8
  tick_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(tick_req && te_bit) |-> (exc_code == 2'b10));

  // R7
  ext_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_code == 2'b01) |-> $past(ie_bit && (|(pend_rd & mask_rd)) && !(tick_req && te_bit)));
endmodule

bind irq_ctrl_top irq_ctrl_chk #(.N(N)) chk_i (
  .clk(clk), .rst_n(rst_n), .tick_req(tick_req), .ie_bit(ie_bit), .te_bit(te_bit),
  .mask_rd(mask_rd), .pend_rd(pend_rd), .hard_req(hard_req),
  .exc_valid(exc_valid), .exc_code(exc_code)
);

// File: tb/irq_ctrl_top_tb.sv
module irq_ctrl_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 13;

  typedef struct packed {
    logic [31:0] irq;
    logic        we;
    logic        sel;
    logic [31:0] wd;
    logic        tick;
    logic        ie;
    logic        te;
    logic [31:0] pend;
    logic [31:0] mask;
    logic        req;
    logic [1:0]  code;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{32'h1,        1'b0,1'b0,32'h0,        1'b0,1'b1,1'b0, 32'h1,        32'h0,        1'b0,2'b00},
    '{32'h1,        1'b1,1'b0,32'h3,        1'b0,1'b1,1'b0, 32'h1,        32'h3,        1'b1,2'b01},
    '{32'h1,        1'b1,1'b0,32'h10,       1'b0,1'b0,1'b0, 32'h1,        32'h13,       1'b1,2'b00},
    '{32'h1,        1'b0,1'b0,32'h0,        1'b1,1'b1,1'b1, 32'h1,        32'h13,       1'b1,2'b10},
    '{32'h1,        1'b0,1'b0,32'h0,        1'b1,1'b1,1'b0, 32'h1,        32'h13,       1'b1,2'b01},
    '{32'h1,        1'b1,1'b1,32'h1,        1'b0,1'b1,1'b0, 32'h0,        32'h13,       1'b0,2'b00},
    '{32'h0,        1'b0,1'b0,32'h0,        1'b0,1'b1,1'b0, 32'h0,        32'h13,       1'b0,2'b00},
    '{32'h10,       1'b0,1'b0,32'h0,        1'b0,1'b1,1'b0, 32'h10,       32'h13,       1'b1,2'b01},
    '{32'h10,       1'b1,1'b0,32'h0,        1'b0,1'b1,1'b0, 32'h10,       32'h13,       1'b1,2'b01},
    '{32'h30,       1'b1,1'b1,32'hFFFFFFFF, 1'b0,1'b1,1'b1, 32'h20,       32'h13,       1'b0,2'b00},
    '{32'h80000000, 1'b1,1'b0,32'h80000000, 1'b0,1'b1,1'b0, 32'h80000000, 32'h80000013, 1'b1,2'b01},
    '{32'h80000000, 1'b0,1'b0,32'h0,        1'b1,1'b0,1'b1, 32'h80000000, 32'h80000013, 1'b1,2'b10},
    '{32'h0,        1'b0,1'b0,32'h0,        1'b0,1'b1,1'b0, 32'h0,        32'h80000013, 1'b0,2'b00}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_lines = '0;
  logic        wr_en = 1'b0, wr_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic        tick_req = 1'b0, ie_bit = 1'b0, te_bit = 1'b0;
  logic [31:0] mask_rd, pend_rd;
  logic        hard_req, exc_valid;
  logic [1:0]  exc_code;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_ctrl_top dut_i (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .tick_req(tick_req), .ie_bit(ie_bit), .te_bit(te_bit),
    .mask_rd(mask_rd), .pend_rd(pend_rd), .hard_req(hard_req),
    .exc_valid(exc_valid), .exc_code(exc_code)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 mask", mask_rd, 0);
    check("R1 pend", pend_rd, 0);
    check("R1 req/valid/code", {hard_req, exc_valid, exc_code}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: R2 R3 R4 R5 R6 R7 R8 R9
    for (int v = 0; v < NV; v++) begin
      irq_lines = VECS[v].irq; wr_en = VECS[v].we; wr_sel = VECS[v].sel;
      wr_data = VECS[v].wd; tick_req = VECS[v].tick; ie_bit = VECS[v].ie; te_bit = VECS[v].te;
      @(negedge clk);
      wr_en = 1'b0;
      @(negedge clk);
      check($sformatf("R2/R4/R5 pend v%0d", v), pend_rd, VECS[v].pend);
      check($sformatf("R3 mask v%0d", v), mask_rd, VECS[v].mask);
      check($sformatf("R6 hard_req v%0d", v), {31'b0, hard_req}, {31'b0, VECS[v].req});
      check($sformatf("R7/R8 code v%0d", v), {30'b0, exc_code}, {30'b0, VECS[v].code});
      check($sformatf("R9 valid v%0d", v), {31'b0, exc_valid}, {31'b0, (VECS[v].code != 2'b00)});
    end

    // R10 readout is immediate; R6 request lags one edge
    ie_bit = 1'b1; tick_req = 1'b0; te_bit = 1'b0;
    irq_lines = 32'h2;
    @(negedge clk);
    check("R10 pend immediate", pend_rd, 32'h2);
    check("R6 req not yet", {31'b0, hard_req}, 0);
    @(negedge clk);
    check("R6 req after one edge", {31'b0, hard_req}, 1);
    check("R7 ext code", {30'b0, exc_code}, 1);

    // R4 clear while line held; stays clear
    wr_en = 1'b1; wr_sel = 1'b1; wr_data = 32'h2;
    @(negedge clk);
    wr_en = 1'b0;
    check("R10 pend cleared immediate", pend_rd, 32'h0);
    repeat (2) @(negedge clk);
    check("R4 stays clear with line high", pend_rd, 32'h0);
    check("R6 req drops", {31'b0, hard_req}, 0);

    // R1 reset again clears mask
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 mask after reset", mask_rd, 0);
    check("R1 pend after reset", pend_rd, 0);
    check("R1 outputs after reset", {hard_req, exc_valid, exc_code}, 0);

    done = 1;
    finish_run();
  end
endmodule